// File: doc/BRIEF.md
# Flash Write Status Reporter

This block sits beside the controller of an emulated flash bank and supplies what a host read of that bank returns while an internal program or erase runs. The controller raises a busy level once it has accepted the last write strobe of a command (the fourth strobe for a program, the sixth for an erase) and holds it until the internal operation ends. While busy is high, a read returns a status word instead of array data. Bit 7 is a polling bit: it shows the inverted target bit during a program and 0 during an erase. Bit 6 alternates on every read.

After a program finishes, the bank does not return to array reads at once. For a settling window, bit 7 shows the true programmed value, bit 6 stays frozen and the remaining bits read as zero. The window length is a parameter counted in clock cycles. An erase has no window. A ready/busy indication is pulled low for the whole internal operation, but only while the bank is selected and its output enable is active. It is released during reset.

Top module: `flash_status_reporter`

## Requirements
- R1: While `ctl_busy` is 1 and `op_kind` is 0 (program), bit 7 of `rd_data` equals the inverse of `prog_poll_bit`.
- R2: While `ctl_busy` is 1 and `op_kind` is 1 (erase), bit 7 of `rd_data` is 0. No settling window follows an erase, so array data comes back in the first cycle after busy drops.
- R3: During busy, bit 6 of `rd_data` changes after each cycle in which `rd_strobe` is 1 and holds after each cycle without a strobe.
- R4: In the first busy cycle of every operation, bit 6 reads 0, whatever value the previous operation left behind.
- R5: Status replaces array data in the very cycle `ctl_busy` first goes to 1, with no added latency.
- R6: When busy drops after a program, `rd_data` shows the settling word for exactly `SETTLE_CYC` cycles, starting in the cycle of the drop. In that word, bit 7 is the last sampled `prog_poll_bit`, bit 6 is frozen at the last toggle value, and all other bits are 0.
- R7: `rb_low` is 1 only when `ctl_busy` is 1, `oe_n` is 0, `ce_n` is 0 and `rst_n` is 1.
- R8: With no operation and no settling window, `rd_data` equals `array_word`.
- R9: During busy, every bit of `rd_data` other than bits 6 and 7 is 0.
- R10: If busy rises again during a settling window, the window ends at once and does not resume after the new operation.
- R11: After reset, with busy low, `rd_data` equals `array_word`, and the first later operation starts with bit 6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_busy | input | 1 | Internal program or erase in progress, from the controller |
| op_kind | input | 1 | 0 = program, 1 = erase; valid while busy |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed; valid while busy |
| rd_strobe | input | 1 | One-cycle pulse per host read of the bank |
| oe_n | input | 1 | Host output enable, active low |
| ce_n | input | 1 | Bank select, active low |
| array_word | input | DATA_W | Array data for the address being read |
| rd_data | output | DATA_W | Word returned to the host |
| rd_data_rb | — | — | (not present) |
| rb_low | output | 1 | 1 = ready/busy line pulled low |

## Verification
The assertions assume that `op_kind` and `prog_poll_bit` stay stable throughout one busy period, and that `ctl_busy` is a clean level that changes only at clock edges. The polling checks compare the output against these inputs in the same cycle, so they rely on this stability. The stimulus drives all inputs once per cycle at the falling edge. It picks an operation kind and a target bit when busy rises and holds them until busy falls. Random read strobes, selects and restarts during the settling window vary around those fixed values.

// File: rtl/fwsr_pkg.sv
package fwsr_pkg;
   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_e;

   localparam int POLL_POS = 7;
   localparam int TOG_POS  = 6;
endpackage

// File: rtl/fwsr_track.sv
module fwsr_track #(
   parameter int SETTLE_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_busy,
   input  logic op_kind,
   input  logic prog_poll_bit,
   output logic op_rise,
   output logic in_settle,
   output logic held_bit
);
   import fwsr_pkg::*;

   localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   logic busy_q;
   logic kind_q;
   logic bit_q;
   logic prog_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= 1'b0;
         bit_q  <= 1'b0;
      end else begin
         busy_q <= ctl_busy;
         if (ctl_busy) begin
            kind_q <= op_kind;
            bit_q  <= prog_poll_bit;
         end
      end
   end

   assign op_rise   = ctl_busy & ~busy_q;
   assign prog_fall = busy_q & ~ctl_busy & (kind_q == OP_PROG);
   assign held_bit  = bit_q;

   generate
      if (SETTLE_CYC == 1) begin : g_single
         assign in_settle = prog_fall;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (op_rise) begin
               cnt_q <= '0;
            end else if (prog_fall) begin
               cnt_q <= CW'(SETTLE_CYC - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign in_settle = prog_fall | (cnt_q != '0);
      end
   endgenerate

   // R6: a window only ever opens on the cycle busy falls
   assert_settle_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_settle) |-> ($past(ctl_busy) && !ctl_busy));

   // R10: once a new operation is under way, no window is active
   assert_busy_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_busy && $past(ctl_busy)) |-> !in_settle);
endmodule

// File: rtl/fwsr_toggle.sv
module fwsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_busy,
   input  logic op_rise,
   input  logic rd_strobe,
   output logic tog_bit
);
   logic tog_q;

   assign tog_bit = op_rise ? 1'b0 : tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (ctl_busy) begin
         tog_q <= tog_bit ^ rd_strobe;
      end
   end

   // R3: a read during busy flips the bit seen in the next busy cycle
   assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_busy && $past(ctl_busy) && $past(rd_strobe)) |-> (tog_bit != $past(tog_bit)));

   // R3: no read, no change
   assert_toggle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_busy && $past(ctl_busy) && !$past(rd_strobe)) |-> (tog_bit == $past(tog_bit)));

   // R4: a fresh operation starts from zero
   assert_toggle_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_rise |-> !tog_bit);
endmodule

// File: rtl/fwsr_word.sv
module fwsr_word #(
   parameter int DATA_W = 16
) (
   input  logic              ctl_busy,
   input  logic              op_kind,
   input  logic              prog_poll_bit,
   input  logic              in_settle,
   input  logic              held_bit,
   input  logic              tog_bit,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rd_data
);
   import fwsr_pkg::*;

   logic poll_live;

   assign poll_live = (op_kind == OP_ERASE) ? 1'b0 : ~prog_poll_bit;

   always_comb begin
      rd_data = '0;
      if (ctl_busy) begin
         rd_data[POLL_POS] = poll_live;
         rd_data[TOG_POS]  = tog_bit;
      end else if (in_settle) begin
         rd_data[POLL_POS] = held_bit;
         rd_data[TOG_POS]  = tog_bit;
      end else begin
         rd_data = array_word;
      end
   end
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
   parameter int DATA_W     = 16,
   parameter int SETTLE_CYC = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_busy,
   input  logic              op_kind,
   input  logic              prog_poll_bit,
   input  logic              rd_strobe,
   input  logic              oe_n,
   input  logic              ce_n,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              rb_low
);
   import fwsr_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("flash_status_reporter: DATA_W must be at least 8");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("flash_status_reporter: SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic op_rise;
   logic in_settle;
   logic held_bit;
   logic tog_bit;

   fwsr_track #(.SETTLE_CYC(SETTLE_CYC)) u_track (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_busy      (ctl_busy),
      .op_kind       (op_kind),
      .prog_poll_bit (prog_poll_bit),
      .op_rise       (op_rise),
      .in_settle     (in_settle),
      .held_bit      (held_bit)
   );

   fwsr_toggle u_toggle (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_busy  (ctl_busy),
      .op_rise   (op_rise),
      .rd_strobe (rd_strobe),
      .tog_bit   (tog_bit)
   );

   fwsr_word #(.DATA_W(DATA_W)) u_word (
      .ctl_busy      (ctl_busy),
      .op_kind       (op_kind),
      .prog_poll_bit (prog_poll_bit),
      .in_settle     (in_settle),
      .held_bit      (held_bit),
      .tog_bit       (tog_bit),
      .array_word    (array_word),
      .rd_data       (rd_data)
   );

   assign rb_low = rst_n & ctl_busy & ~oe_n & ~ce_n;

   // R1: program polling shows the inverted target bit
   assert_prog_poll_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_busy && op_kind == OP_PROG) |-> (rd_data[POLL_POS] != prog_poll_bit));

   // R2: erase polling reads zero
   assert_erase_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_busy && op_kind == OP_ERASE) |-> !rd_data[POLL_POS]);

   // R7: released whenever deselected or output disabled
   assert_rb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || ce_n || !ctl_busy) |-> !rb_low);

   // R9: filler bits are zero during busy
   assert_busy_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_busy |-> ($countones(rd_data) <= 2));

   // R8: no operation and no window means array data passes
   assert_idle_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_busy && !in_settle) |-> (rd_data == array_word));
endmodule

// File: tb/sim_flash_status_reporter.sv
module sim_flash_status_reporter;
   localparam int W  = 16;
   localparam int ST = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_busy = 1'b0;
   logic         op_kind = 1'b0;
   logic         prog_poll_bit = 1'b0;
   logic         rd_strobe = 1'b0;
   logic         oe_n = 1'b1;
   logic         ce_n = 1'b1;
   logic [W-1:0] array_word = '0;
   logic [W-1:0] rd_data;
   logic         rb_low;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic m_prev = 1'b0;
   logic m_tog  = 1'b0;
   logic m_kind = 1'b0;
   logic m_bit  = 1'b0;
   int   m_cnt  = 0;
   string dtag = "";

   always #5 clk = ~clk;

   flash_status_reporter #(.DATA_W(W), .SETTLE_CYC(ST)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_busy(ctl_busy), .op_kind(op_kind),
      .prog_poll_bit(prog_poll_bit), .rd_strobe(rd_strobe), .oe_n(oe_n),
      .ce_n(ce_n), .array_word(array_word), .rd_data(rd_data), .rb_low(rb_low)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   function automatic logic [W-1:0] status_word(input logic b7, input logic b6);
      logic [W-1:0] w;
      w = '0;
      w[7] = b7;
      w[6] = b6;
      return w;
   endfunction

   task automatic step(input logic b, input logic k, input logic p, input logic r,
                       input logic o, input logic c, input logic [W-1:0] a);
      logic rise, fall, teff, settle;
      logic [W-1:0] exp;
      @(negedge clk);
      ctl_busy = b; op_kind = k; prog_poll_bit = p; rd_strobe = r;
      oe_n = o; ce_n = c; array_word = a;
      #2;
      rise   = b & ~m_prev;
      fall   = m_prev & ~b;
      teff   = rise ? 1'b0 : m_tog;
      settle = ~b & ((m_cnt > 0) | (fall & ~m_kind));
      if (b) begin
         chk(k ? "R2" : (rise ? "R5" : "R1"), {{(W-1){1'b0}}, rd_data[7]},
             {{(W-1){1'b0}}, (k ? 1'b0 : ~p)});
         chk(rise ? "R4" : "R3", {{(W-1){1'b0}}, rd_data[6]}, {{(W-1){1'b0}}, teff});
         chk("R9", rd_data & ~status_word(1'b1, 1'b1), '0);
      end else if (settle) begin
         exp = status_word(m_bit, m_tog);
         chk("R6", rd_data, exp);
      end else begin
         chk(dtag != "" ? dtag : "R8", rd_data, a);
      end
      chk("R7", {{(W-1){1'b0}}, rb_low}, {{(W-1){1'b0}}, (b & ~o & ~c & rst_n)});
      @(posedge clk);
      if (b) m_tog = teff ^ r;
      if (rise) m_cnt = 0;
      else if (fall && !m_kind) m_cnt = ST - 1;
      else if (m_cnt > 0) m_cnt--;
      if (b) begin m_kind = k; m_bit = p; end
      m_prev = b;
   endtask

   task automatic run_op(input logic k, input logic p, input int len, input int rdpct);
      for (int i = 0; i < len; i++) begin
         step(1'b1, k, p, (($urandom % 100) < rdpct), ($urandom % 4) == 0,
              ($urandom % 5) == 0, W'($urandom));
      end
   endtask

   task automatic idle(input int len);
      for (int i = 0; i < len; i++) begin
         step(1'b0, 1'(($urandom % 2)), 1'(($urandom % 2)), 1'(($urandom % 2)),
              1'b0, 1'b0, W'($urandom));
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected below 100000", cycles);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd7341));
      // R11: reset state, busy high during reset keeps ready/busy released
      @(negedge clk);
      ctl_busy = 1'b1; oe_n = 1'b0; ce_n = 1'b0; array_word = 16'hA5C3;
      #2;
      chk("R11", {{(W-1){1'b0}}, rb_low}, '0);
      @(negedge clk);
      ctl_busy = 1'b0;
      #2;
      chk("R11", rd_data, 16'hA5C3);
      rst_n = 1'b1;
      dtag = "R11";
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
      dtag = "";

      // R5 / R4: read in the first busy cycle of a program, target bit 1
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF);
      // R6: full settling window then array data
      for (int i = 0; i < ST + 2; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0F0F);

      // R2: erase, no window afterwards
      run_op(1'b1, 1'b0, 6, 50);
      dtag = "R2";
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
      dtag = "";

      // R10: restart during settling window
      run_op(1'b0, 1'b0, 4, 60);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0002);
      run_op(1'b1, 1'b1, 3, 60);
      dtag = "R10";
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7E7E);
      dtag = "";

      // random mix
      for (int n = 0; n < 80; n++) begin
         idle($urandom % 4);
         run_op(1'($urandom % 2), 1'($urandom % 2), 1 + ($urandom % 18), 1 + ($urandom % 90));
         idle($urandom % (ST + 3));
      end
      idle(ST + 2);
      finish_run();
   end
endmodule